// File: doc/BRIEF.md
# Two-Space I2C Target with Independent Address Pointers

This block is an I2C target that listens for two device identifiers on one bus. The first identifier opens a byte-wide memory array that is addressed with two address bytes. The second opens a bank of sixteen byte registers that is addressed with one address byte. Each space keeps its own current-address pointer. A transfer to one space therefore never moves the pointer of the other. A host can break into a long memory read to touch a register, then carry on reading memory where it stopped without sending the address again.

SCL and SDA are sampled with the system clock through two-flop synchronizers. The block detects START, repeated START and STOP, shifts bytes in and out, and pulls SDA low for acknowledge and for zero data bits. SDA is modelled as an open-drain line: `sdaOutLow` high means the target pulls the wire low. Pointers step after every byte moved, in either direction, and wrap at the top of their space.

Top module: `i2c_dual_ptr_target`

## Requirements
- R1: An address byte is acknowledged only when bits 7:4 equal the memory identifier (default 4'b1010) or the register identifier (default 4'b1101), and bits 3:1 equal the configured select value (default 3'b000). For any other address byte the target leaves SDA released (NACK) and ignores every byte until the next START or STOP, and it changes no pointer and no data.
- R2: Bit 0 of the address byte sets the direction: 0 means the host writes, 1 means the target sends data.
- R3: A memory write sends the high address byte, then the low address byte, then data. Each data byte is stored at the pointer, starting at the loaded address. Address bits above the array depth (default 512 bytes, so bits 15:9) are ignored.
- R4: A register write sends one address byte (bits 3:0 used), then data stored from that register onward.
- R5: A read-direction address byte starts a current-address read. The first data bit, MSB first, is driven in the SCL low phase right after the address ACK and comes from the selected space's pointer.
- R6: The selected pointer advances by one after every data byte written or read. The memory pointer wraps from depth-1 to 0, and the register pointer wraps from 15 to 0.
- R7: A selective read is an address write, a repeated START, then a read-direction address byte. The repeated START stores no data and keeps the loaded address, so the read starts there.
- R8: Loading or stepping the register pointer leaves the memory pointer unchanged, and the reverse also holds.
- R9: The host ends a read with NACK on the last byte and then STOP. After this the target keeps SDA released, and a STOP always leaves SDA released.
- R10: After reset SDA is released, both pointers are zero and all registers read 0x00.
- R11: The target changes its SDA drive only while SCL is low. The only exception is a release caused by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired level) |
| sdaOutLow | output | 1 | High to pull the data line low |

## Verification
A data byte can be stored and the memory pointer can step in the same clock, and at the top of the array that step is also the wrap to zero. The bench writes two bytes starting at the last memory location, so the second store lands at address zero. It then reads both back with a selective read, where the read-side increment wraps the same way. Each returned byte is matched by the scoreboard against a model that holds its own pointers. A second case overlaps a register access with a paused memory read: the scoreboard requires the memory read to resume at the next unread byte.

// File: rtl/i2cdp_pkg.sv
package i2cdp_pkg;

  localparam int REG_AW = 4;
  localparam int REG_DEPTH = 1 << REG_AW;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_MHI,
    ST_MLO,
    ST_RADR,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_MACK
  } ctrlState_t;

  typedef struct packed {
    logic shiftIn;
    logic ackOn;
    logic sdaRelease;
    logic loadTx;
    logic shiftTx;
    logic setSpaceReg;
    logic setSpaceMem;
    logic loadMemHi;
    logic loadMemLo;
    logic loadRegPtr;
    logic storeByte;
    logic incPtr;
  } dpStrobe_t;

endpackage

// File: rtl/i2cdp_front.sv
module i2cdp_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclSync,
  output logic sdaSync,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclSync  = sclPipe[SYNC_STAGES-1];
  assign sdaSync  = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

endmodule

// File: rtl/i2cdp_ctrl.sv
module i2cdp_ctrl
  import i2cdp_pkg::*;
#(
  parameter logic [3:0] MEM_ID  = 4'b1010,
  parameter logic [3:0] REG_ID  = 4'b1101,
  parameter logic [2:0] DEV_SEL = 3'b000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaSync,
  input  logic [7:0] rxByte,
  output dpStrobe_t stb
);

  ctrlState_t st, stNext;
  ctrlState_t retSt, retNext;
  logic [2:0] bitCnt, bitNext;
  logic gotByte, gotNext;
  logic masterNack, nackNext;
  logic isMem, isReg;

  assign isMem = (rxByte[7:4] == MEM_ID) && (rxByte[3:1] == DEV_SEL);
  assign isReg = (rxByte[7:4] == REG_ID) && (rxByte[3:1] == DEV_SEL);

  always_comb begin
    stb      = '0;
    stNext   = st;
    retNext  = retSt;
    bitNext  = bitCnt;
    gotNext  = gotByte;
    nackNext = masterNack;
    if (stopDet) begin
      stb.sdaRelease = 1'b1;
      stNext = ST_IDLE;
    end else if (startDet) begin
      stb.sdaRelease = 1'b1;
      stNext  = ST_DEV;
      bitNext = '0;
      gotNext = 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_MHI, ST_MLO, ST_RADR, ST_WDAT: begin
          if (sclRise && !gotByte) begin
            stb.shiftIn = 1'b1;
            bitNext = bitCnt + 3'd1;
            gotNext = (bitCnt == 3'd7);
          end else if (sclFall && gotByte) begin
            gotNext = 1'b0;
            bitNext = '0;
            case (st)
              ST_DEV: begin
                if (isMem || isReg) begin
                  stb.ackOn = 1'b1;
                  stb.setSpaceReg = isReg;
                  stb.setSpaceMem = isMem;
                  stNext = ST_ACK;
                  if (rxByte[0]) retNext = ST_RDAT;
                  else if (isMem) retNext = ST_MHI;
                  else retNext = ST_RADR;
                end else begin
                  stNext = ST_IDLE;
                end
              end
              ST_MHI: begin
                stb.loadMemHi = 1'b1;
                stb.ackOn = 1'b1;
                stNext = ST_ACK;
                retNext = ST_MLO;
              end
              ST_MLO: begin
                stb.loadMemLo = 1'b1;
                stb.ackOn = 1'b1;
                stNext = ST_ACK;
                retNext = ST_WDAT;
              end
              ST_RADR: begin
                stb.loadRegPtr = 1'b1;
                stb.ackOn = 1'b1;
                stNext = ST_ACK;
                retNext = ST_WDAT;
              end
              default: begin
                stb.storeByte = 1'b1;
                stb.incPtr = 1'b1;
                stb.ackOn = 1'b1;
                stNext = ST_ACK;
                retNext = ST_WDAT;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            stNext  = retSt;
            bitNext = '0;
            gotNext = 1'b0;
            if (retSt == ST_RDAT) stb.loadTx = 1'b1;
            else stb.sdaRelease = 1'b1;
          end
        end
        ST_RDAT: begin
          if (sclRise && !gotByte) begin
            bitNext = bitCnt + 3'd1;
            gotNext = (bitCnt == 3'd7);
          end else if (sclFall) begin
            if (gotByte) begin
              stb.sdaRelease = 1'b1;
              stb.incPtr = 1'b1;
              gotNext = 1'b0;
              stNext = ST_MACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            nackNext = sdaSync;
          end else if (sclFall) begin
            bitNext = '0;
            if (!masterNack) begin
              stb.loadTx = 1'b1;
              stNext = ST_RDAT;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      retSt      <= ST_IDLE;
      bitCnt     <= '0;
      gotByte    <= 1'b0;
      masterNack <= 1'b1;
    end else begin
      st         <= stNext;
      retSt      <= retNext;
      bitCnt     <= bitNext;
      gotByte    <= gotNext;
      masterNack <= nackNext;
    end
  end

endmodule

// File: rtl/i2cdp_datapath.sv
module i2cdp_datapath
  import i2cdp_pkg::*;
#(
  parameter int MEM_DEPTH = 512,
  localparam int MEM_AW = $clog2(MEM_DEPTH),
  localparam int HI_W = (MEM_AW > 8) ? MEM_AW - 8 : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaSync,
  output logic [7:0]        rxByte,
  output logic              sdaOutLow,
  output logic [MEM_AW-1:0] memPtr,
  output logic [REG_AW-1:0] regPtr,
  output logic              selReg
);

  logic [7:0] memArr [MEM_DEPTH];
  logic [7:0] regBank [REG_DEPTH];
  logic [HI_W-1:0] memHi;
  logic [7:0] txByte;
  logic [7:0] rdData;

  assign rdData = selReg ? regBank[regPtr] : memArr[memPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte    <= '0;
      txByte    <= '0;
      sdaOutLow <= 1'b0;
      memHi     <= '0;
      memPtr    <= '0;
      regPtr    <= '0;
      selReg    <= 1'b0;
    end else begin
      if (stb.shiftIn) rxByte <= {rxByte[6:0], sdaSync};

      if (stb.ackOn) begin
        sdaOutLow <= 1'b1;
      end else if (stb.loadTx) begin
        txByte    <= rdData;
        sdaOutLow <= ~rdData[7];
      end else if (stb.shiftTx) begin
        txByte    <= {txByte[6:0], 1'b0};
        sdaOutLow <= ~txByte[6];
      end else if (stb.sdaRelease) begin
        sdaOutLow <= 1'b0;
      end

      if (stb.setSpaceReg) selReg <= 1'b1;
      else if (stb.setSpaceMem) selReg <= 1'b0;

      if (stb.loadMemHi) memHi <= rxByte[HI_W-1:0];

      if (stb.loadMemLo) memPtr <= MEM_AW'({memHi, rxByte});
      else if (stb.incPtr && !selReg) memPtr <= memPtr + MEM_AW'(1);

      if (stb.loadRegPtr) regPtr <= rxByte[REG_AW-1:0];
      else if (stb.incPtr && selReg) regPtr <= regPtr + REG_AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeByte && !selReg) memArr[memPtr] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_DEPTH; i++) regBank[i] <= '0;
    end else if (stb.storeByte && selReg) begin
      regBank[regPtr] <= rxByte;
    end
  end

endmodule

// File: rtl/i2c_dual_ptr_target.sv
module i2c_dual_ptr_target
  import i2cdp_pkg::*;
#(
  parameter int MEM_DEPTH = 512,
  parameter logic [3:0] MEM_ID  = 4'b1010,
  parameter logic [3:0] REG_ID  = 4'b1101,
  parameter logic [2:0] DEV_SEL = 3'b000,
  localparam int MEM_AW = $clog2(MEM_DEPTH)
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOutLow
);

  logic sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  logic [MEM_AW-1:0] memPtr;
  logic [REG_AW-1:0] regPtr;
  logic selReg;
  dpStrobe_t stb;

  i2cdp_front #(.SYNC_STAGES(2)) u_front (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  i2cdp_ctrl #(.MEM_ID(MEM_ID), .REG_ID(REG_ID), .DEV_SEL(DEV_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaSync(sdaSync),
    .rxByte(rxByte), .stb(stb)
  );

  i2cdp_datapath #(.MEM_DEPTH(MEM_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaSync(sdaSync),
    .rxByte(rxByte), .sdaOutLow(sdaOutLow), .memPtr(memPtr),
    .regPtr(regPtr), .selReg(selReg)
  );

endmodule

// File: rtl/i2cdp_checker.sv
module i2cdp_checker
  import i2cdp_pkg::*;
#(
  parameter int MEM_AW = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclSync,
  input logic              startDet,
  input logic              stopDet,
  input logic              sdaOutLow,
  input dpStrobe_t         stb,
  input logic [MEM_AW-1:0] memPtr,
  input logic [REG_AW-1:0] regPtr,
  input logic              selReg
);

  // R10: while reset is held the line is released
  always @(posedge clk) begin
    if (!rstN) begin
      a_r10_reset_release: assert (!sdaOutLow);
    end
  end

  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOutLow != $past(sdaOutLow)) && !$past(startDet || stopDet) |-> !sclSync);

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOutLow);

  a_r8_reg_ops_keep_memptr: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadRegPtr || (stb.incPtr && selReg)) |=> $stable(memPtr));

  a_r6_memptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incPtr && !selReg && !stb.loadMemLo) |=> memPtr == $past(memPtr) + MEM_AW'(1));

  a_r4_regptr_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadRegPtr || (stb.incPtr && selReg)) |=> $stable(regPtr));

  a_r1_single_space: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setSpaceReg && stb.setSpaceMem));

endmodule

bind i2c_dual_ptr_target i2cdp_checker #(.MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .startDet(startDet),
  .stopDet(stopDet), .sdaOutLow(sdaOutLow), .stb(stb), .memPtr(memPtr),
  .regPtr(regPtr), .selReg(selReg)
);

// File: tb/i2c_dual_ptr_target_tb.sv
module i2c_dual_ptr_target_tb;

  localparam int Q = 10;
  localparam int MDEPTH = 512;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b1;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaIn;
  logic sdaOutLow;
  assign sdaIn = sdaM & ~sdaOutLow;

  i2c_dual_ptr_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaIn), .sdaOutLow(sdaOutLow)
  );

  int nChk = 0;
  int nFail = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic [7:0] obsVal;
  event obsEv;
  logic [7:0] memM [MDEPTH];
  logic [7:0] regM [16];
  int memP = 0;
  int regP = 0;
  logic [7:0] wrQ[$];
  int r11Bad = 0;
  logic prevLow = 1'b0;
  bit finished = 1'b0;

  task automatic check(string tag, int got, int exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items as the bus yields results
  initial begin
    forever begin
      @(obsEv);
      if (expQ.size() == 0) begin
        check("scoreboard empty", int'(obsVal), -1);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, int'(obsVal), int'(e));
      end
    end
  end

  // R11: drive may move only while SCL is low
  always @(posedge clk) begin
    if (rstN && (sdaOutLow !== prevLow) && sclM) r11Bad++;
    prevLow <= sdaOutLow;
  end

  function automatic logic [7:0] devByte(bit isReg, bit rd);
    return {isReg ? 4'b1101 : 4'b1010, 3'b000, rd};
  endfunction

  task automatic busStart();
    sdaM = 1'b1; hold(Q);
    sclM = 1'b1; hold(Q);
    sdaM = 1'b0; hold(Q);
    sclM = 1'b0; hold(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; hold(Q);
    sclM = 1'b1; hold(Q);
    sdaM = 1'b1; hold(Q);
  endtask

  task automatic sendByte(logic [7:0] b, string tag, bit expAck);
    expQ.push_back({7'b0, ~expAck});
    tagQ.push_back({tag, " ack"});
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; hold(Q);
      sclM = 1'b1; hold(2 * Q);
      sclM = 1'b0; hold(Q);
    end
    sdaM = 1'b1; hold(Q);
    sclM = 1'b1; hold(Q);
    obsVal = {7'b0, sdaIn};
    -> obsEv;
    hold(Q);
    sclM = 1'b0; hold(Q);
  endtask

  task automatic recvByte(logic [7:0] exp, string tag, bit mAck);
    logic [7:0] r;
    expQ.push_back(exp);
    tagQ.push_back({tag, " data"});
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; hold(Q);
      sclM = 1'b1; hold(Q);
      r[i] = sdaIn;
      hold(Q);
      sclM = 1'b0; hold(Q);
    end
    obsVal = r;
    -> obsEv;
    sdaM = mAck ? 1'b0 : 1'b1; hold(Q);
    sclM = 1'b1; hold(2 * Q);
    sclM = 1'b0; hold(Q);
    sdaM = 1'b1;
  endtask

  task automatic memWrite(int addr, string tag);
    busStart();
    sendByte(devByte(0, 0), {tag, " R2 write dir"}, 1);
    sendByte(addr[15:8], {tag, " R3 addr hi"}, 1);
    sendByte(addr[7:0], {tag, " R3 addr lo"}, 1);
    memP = addr % MDEPTH;
    foreach (wrQ[i]) begin
      sendByte(wrQ[i], {tag, " R3 data"}, 1);
      memM[memP] = wrQ[i];
      memP = (memP + 1) % MDEPTH;
    end
    busStop();
    wrQ.delete();
  endtask

  task automatic regWrite(int addr, string tag);
    busStart();
    sendByte(devByte(1, 0), {tag, " R2 write dir"}, 1);
    sendByte(addr[7:0], {tag, " R4 addr"}, 1);
    regP = addr % 16;
    foreach (wrQ[i]) begin
      sendByte(wrQ[i], {tag, " R4 data"}, 1);
      regM[regP] = wrQ[i];
      regP = (regP + 1) % 16;
    end
    busStop();
    wrQ.delete();
  endtask

  task automatic curRead(bit isReg, int n, string tag);
    busStart();
    sendByte(devByte(isReg, 1), {tag, " R2 read dir"}, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      if (isReg) begin
        e = regM[regP];
        regP = (regP + 1) % 16;
      end else begin
        e = memM[memP];
        memP = (memP + 1) % MDEPTH;
      end
      recvByte(e, {tag, " R5"}, i < n - 1);
    end
    busStop();
    hold(Q);
    check({tag, " R9 released after stop"}, int'(sdaOutLow), 0);
  endtask

  task automatic selMem(int addr, int n, string tag);
    busStart();
    sendByte(devByte(0, 0), {tag, " R7 dev"}, 1);
    sendByte(addr[15:8], {tag, " R7 hi"}, 1);
    sendByte(addr[7:0], {tag, " R7 lo"}, 1);
    memP = addr % MDEPTH;
    curRead(0, n, {tag, " R7"});
  endtask

  task automatic selReg(int addr, int n, string tag);
    busStart();
    sendByte(devByte(1, 0), {tag, " R7 dev"}, 1);
    sendByte(addr[7:0], {tag, " R7 addr"}, 1);
    regP = addr % 16;
    curRead(1, n, {tag, " R7"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regM[i] = 8'h00;
    #5 rstN = 1'b0;
    hold(4);
    check("R10 sda released in reset", int'(sdaOutLow), 0);
    rstN = 1'b1;
    hold(4);
    check("R10 sda released after reset", int'(sdaOutLow), 0);

    curRead(1, 2, "R10 reg bank cleared");

    wrQ = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    memWrite(16'h0010, "R3 block");
    selMem(16'h0010, 2, "R7 mem");

    wrQ = '{8'hA1, 8'hB2};
    regWrite(3, "R4 regs");
    selReg(3, 2, "R4 readback");

    curRead(0, 2, "R8 mem resumes");
    curRead(1, 1, "R8 reg resumes");
    curRead(0, 1, "R6 mem step");

    wrQ = '{8'h77};
    memWrite(16'hFE20, "R3 high bits");
    selMem(16'h0020, 1, "R3 alias");

    wrQ = '{8'hE1, 8'hE2};
    memWrite(16'h01FF, "R6 mem wrap");
    selMem(16'h01FF, 2, "R6 mem wrap");

    wrQ = '{8'h5A, 8'h6B};
    regWrite(15, "R6 reg wrap");
    selReg(15, 2, "R6 reg wrap");

    selMem(16'h0010, 1, "R1 setup");
    busStart();
    sendByte(8'hB0, "R1 foreign id", 0);
    sendByte(8'h5A, "R1 ignored byte", 0);
    busStop();
    busStart();
    sendByte(8'hA2, "R1 wrong select", 0);
    busStop();
    hold(Q);
    check("R1 no drive after foreign id", int'(sdaOutLow), 0);
    curRead(0, 1, "R1 pointer kept");

    check("R11 drive changes with SCL high", r11Bad, 0);
    check("R1 scoreboard drained", expQ.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule